// File: doc/BRIEF.md
# Page-Mode Flash Read Sequencer

This block turns one host read request into a multi-beat read from a page-mode ROM or flash device on an external parallel bus. A request carries a start byte address, a beat-count code, a page-size code and a bus-width select. Once a request is accepted, the block asserts chip select and output enable and drives one word address after another. It holds each address for a programmed number of wait cycles and then captures the data bus.

The first beat of a transfer waits the long first-access count. A later beat whose word lies in the same page as the previous one waits only the short page count. A beat that opens a new page falls back to the full first-access count. Each captured word comes out with a one-cycle valid pulse. When the final word has been delivered, the bus lines are released and a one-cycle done pulse is raised.

The request side is a valid/ready handshake. `req_ready` is high only while the bus is idle, and the host must hold its request fields steady until the handshake completes. A request presented while a burst runs waits and is not lost. The returned beats cannot be back-pressured, because the device keeps no state between beats. The consumer must take each word in the cycle its valid pulse is high.

Top module: `pgflash_rd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `flash_cs_n` and `flash_oe_n` are 1, `beat_valid` and `done` are 0, and `req_ready` is 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in every cycle in which `flash_cs_n` is 0. A request held valid during that time has no effect until `req_ready` returns.
- R3: The length code `req_len` selects the number of beats: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. Exactly that many `beat_valid` pulses are produced before `done`.
- R4: The first beat's address is driven for `cfg_first_wait`+1 cycles, starting the cycle after acceptance. The beat's `beat_valid` is high in the cycle that follows.
- R5: A later beat whose word index within the page is not 0 holds its address for `cfg_page_wait`+1 cycles.
- R6: A later beat whose word index within the page is 0 holds its address for `cfg_first_wait`+1 cycles. The page code `req_page` gives 2 words for code 0, 4 for code 1, and 8 for codes 2 and 3.
- R7: Word addresses step up by 1 in 8-bit mode (`req_wide`=0) and by 2 in 16-bit mode (`req_wide`=1). In 16-bit mode bit 0 of `flash_addr` is driven 0. The word index within the page is bits [2:0] in 8-bit mode and bits [3:1] in 16-bit mode. Between beats the address changes only on a beat capture.
- R8: `beat_data` is the value of `flash_data` in the last wait cycle of that beat. In 8-bit mode bits [15:8] read 0.
- R9: `flash_cs_n` and `flash_oe_n` are 0 from the cycle after acceptance through the cycle in which the final `beat_valid` is high, and 1 in the cycle after. `beat_valid` is never high while they are 1.
- R10: `done` is high for exactly one cycle: the cycle right after the final `beat_valid`, which is also the cycle in which the bus lines are released.
- R11: `cfg_first_wait` and `cfg_page_wait` are sampled at acceptance. Changing them during a burst does not change that burst's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | AW | Start byte address |
| req_len | input | 2 | Beat-count code (1/2/4/8) |
| req_page | input | 2 | Page-size code (2/4/8/8 words) |
| req_wide | input | 1 | 1 selects the 16-bit bus, 0 the 8-bit bus |
| cfg_first_wait | input | WW | Wait cycles for a first or page-opening beat |
| cfg_page_wait | input | WW | Wait cycles for an in-page beat |
| flash_addr | output | AW | Byte address to the device |
| flash_cs_n | output | 1 | Chip select, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_data | input | 16 | Read data from the device |
| beat_valid | output | 1 | One-cycle pulse marking a returned word |
| beat_data | output | 16 | Returned word |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
Some properties hold on every cycle, and the bound checker watches those. It checks that ready stays low while the chip is selected, that the address holds between captures, and that bit 0 is clear in 16-bit mode. It also checks that valid pulses only occur on an active bus, that done coincides with release and lasts one cycle, and that the beat count matches the length code. Exact wait lengths, the switch back to the long wait at a page boundary, captured data values, width-dependent zero-extension and the sampling of the wait settings at acceptance depend on the request history. Only the bench's cycle-accurate reference timeline can show these, compared across several addresses, page sizes, lengths and wait settings.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

  localparam int BUS_W  = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = BUS_W / LANE_W;
  localparam int CNT_W  = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_TAIL
  } pgf_state_e;

  function automatic logic [CNT_W-1:0] len_to_beats(input logic [1:0] code);
    case (code)
      2'd0:    len_to_beats = 4'd1;
      2'd1:    len_to_beats = 4'd2;
      2'd2:    len_to_beats = 4'd4;
      default: len_to_beats = 4'd8;
    endcase
  endfunction

  function automatic logic [2:0] page_to_mask(input logic [1:0] code);
    case (code)
      2'd0:    page_to_mask = 3'd1;
      2'd1:    page_to_mask = 3'd3;
      default: page_to_mask = 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/pgf_wait_ctr.sv
module pgf_wait_ctr #(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WW-1:0] load_val,
  output logic          expired
);

  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pgf_addr_step.sv
module pgf_addr_step
  import pgf_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          load_wide,
  input  logic          step,
  input  logic          wide,
  input  logic [1:0]    page_code,
  output logic [AW-1:0] addr,
  output logic          page_end
);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] step_sz;
  logic [2:0]    word_idx;
  logic [2:0]    mask;

  assign step_sz = {{(AW-2){1'b0}}, wide, ~wide};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= {load_addr[AW-1:1], load_addr[0] & ~load_wide};
    end else if (step) begin
      addr_q <= addr_q + step_sz;
    end
  end

  always_comb begin
    word_idx = wide ? addr_q[3:1] : addr_q[2:0];
    mask     = page_to_mask(page_code);
  end

  // next step lands on the first word of a fresh page
  assign page_end = ((word_idx & mask) == mask);
  assign addr     = addr_q;

endmodule

// File: rtl/pgf_beat_cap.sv
module pgf_beat_cap
  import pgf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             wide,
  input  logic [BUS_W-1:0] bus_data,
  output logic             beat_valid,
  output logic [BUS_W-1:0] beat_data
);

  logic [LANES-1:0] lane_en;
  logic [BUS_W-1:0] next_data;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign lane_en[g] = 1'b1;
    end else begin : g_high
      assign lane_en[g] = wide;
    end
    assign next_data[g*LANE_W +: LANE_W] =
      lane_en[g] ? bus_data[g*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_valid <= 1'b0;
      beat_data  <= '0;
    end else begin
      beat_valid <= capture;
      if (capture) begin
        beat_data <= next_data;
      end
    end
  end

endmodule

// File: rtl/pgflash_rd_seq.sv
module pgflash_rd_seq
  import pgf_pkg::*;
#(
  parameter int AW = 24,
  parameter int WW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_len,
  input  logic [1:0]       req_page,
  input  logic             req_wide,
  input  logic [WW-1:0]    cfg_first_wait,
  input  logic [WW-1:0]    cfg_page_wait,
  output logic [AW-1:0]    flash_addr,
  output logic             flash_cs_n,
  output logic             flash_oe_n,
  input  logic [BUS_W-1:0] flash_data,
  output logic             beat_valid,
  output logic [BUS_W-1:0] beat_data,
  output logic             done
);

  pgf_state_e       state_q;
  logic [CNT_W-1:0] left_q;
  logic             wide_q;
  logic [1:0]       page_q;
  logic [WW-1:0]    fw_q;
  logic [WW-1:0]    pw_q;
  logic             done_q;

  logic             accept;
  logic             capture;
  logic             last_beat;
  logic             expired;
  logic             page_end;
  logic             ctr_load;
  logic [WW-1:0]    ctr_val;
  logic             step;

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign capture   = (state_q == ST_ACCESS) && expired;
  assign last_beat = (left_q == 4'd1);
  assign step      = capture && !last_beat;
  assign ctr_load  = accept || step;
  assign ctr_val   = accept ? cfg_first_wait : (page_end ? fw_q : pw_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      wide_q  <= 1'b0;
      page_q  <= '0;
      fw_q    <= '0;
      pw_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_TAIL);
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_ACCESS;
            left_q  <= len_to_beats(req_len);
            wide_q  <= req_wide;
            page_q  <= req_page;
            fw_q    <= cfg_first_wait;
            pw_q    <= cfg_page_wait;
          end
        end
        ST_ACCESS: begin
          if (capture) begin
            left_q <= left_q - 4'd1;
            if (last_beat) begin
              state_q <= ST_TAIL;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  pgf_wait_ctr #(.WW(WW)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctr_load),
    .load_val (ctr_val),
    .expired  (expired)
  );

  pgf_addr_step #(.AW(AW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_addr (req_addr),
    .load_wide (req_wide),
    .step      (step),
    .wide      (wide_q),
    .page_code (page_q),
    .addr      (flash_addr),
    .page_end  (page_end)
  );

  pgf_beat_cap u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (capture),
    .wide       (wide_q),
    .bus_data   (flash_data),
    .beat_valid (beat_valid),
    .beat_data  (beat_data)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign flash_cs_n = (state_q == ST_IDLE);
  assign flash_oe_n = (state_q == ST_IDLE);
  assign done       = done_q;

endmodule

// File: rtl/pgf_chk.sv
module pgf_chk
  import pgf_pkg::*;
#(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_len,
  input logic          req_wide,
  input logic [AW-1:0] flash_addr,
  input logic          flash_cs_n,
  input logic          flash_oe_n,
  input logic          beat_valid,
  input logic          done
);

  logic             wide_seen;
  logic [CNT_W-1:0] exp_beats;
  logic [CNT_W-1:0] got_beats;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wide_seen <= 1'b0;
      exp_beats <= '0;
      got_beats <= '0;
    end else if (req_valid && req_ready) begin
      wide_seen <= req_wide;
      exp_beats <= len_to_beats(req_len);
      got_beats <= '0;
    end else if (beat_valid) begin
      got_beats <= got_beats + 4'd1;
    end
  end

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_cs_n |-> !req_ready);

  p_beat_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (got_beats == exp_beats));

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_oe_n && $past(!flash_oe_n) && !beat_valid) |-> $stable(flash_addr));

  p_even_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_oe_n && wide_seen) |-> !flash_addr[0]);

  p_valid_on_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !flash_oe_n);

  p_release_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_oe_n) |-> done);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind pgflash_rd_seq pgf_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_len    (req_len),
  .req_wide   (req_wide),
  .flash_addr (flash_addr),
  .flash_cs_n (flash_cs_n),
  .flash_oe_n (flash_oe_n),
  .beat_valid (beat_valid),
  .done       (done)
);

// File: tb/sim_pgflash_rd_seq.sv
`timescale 1ns/1ps
module sim_pgflash_rd_seq;

  localparam int AW = 24;
  localparam int WW = 4;

  typedef struct {
    bit        oe_n;
    bit        chk_addr;
    int        addr;
    bit        bv;
    int        data;
    bit        dn;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_len = '0;
  logic [1:0]    req_page = '0;
  logic          req_wide = 1'b0;
  logic [WW-1:0] cfg_first_wait = 4'd3;
  logic [WW-1:0] cfg_page_wait = 4'd1;
  logic [AW-1:0] flash_addr;
  logic          flash_cs_n;
  logic          flash_oe_n;
  logic [15:0]   flash_data;
  logic          beat_valid;
  logic [15:0]   beat_data;
  logic          done;

  int   n_run = 0;
  int   n_fail = 0;
  exp_t exp_q[$];
  int   beats_seen = 0;
  int   beats_want = 0;

  always #4 clk = ~clk;

  function automatic int fdat(input int a);
    fdat = (((a & 8'hFF) ^ 8'hA5) << 8) | ((((a >> 8) & 8'hFF) + (a & 8'hFF)) & 8'hFF);
  endfunction

  assign flash_data = 16'(fdat(int'(flash_addr)));

  pgflash_rd_seq #(.AW(AW), .WW(WW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_page(req_page), .req_wide(req_wide),
    .cfg_first_wait(cfg_first_wait), .cfg_page_wait(cfg_page_wait),
    .flash_addr(flash_addr), .flash_cs_n(flash_cs_n), .flash_oe_n(flash_oe_n),
    .flash_data(flash_data), .beat_valid(beat_valid), .beat_data(beat_data), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference timeline for one accepted request (R3..R11)
  task automatic build(input int a0, input int lc, input int pc, input bit w,
                       input int fw, input int pw);
    int n, mask, a, prev, last;
    exp_t e;
    n    = (lc == 0) ? 1 : (lc == 1) ? 2 : (lc == 2) ? 4 : 8;
    mask = (pc == 0) ? 1 : (pc == 1) ? 3 : 7;
    a    = w ? (a0 & ~1) : a0;
    prev = 0;
    last = a;
    for (int i = 0; i < n; i++) begin
      int idx, wt;
      idx = w ? ((a >> 1) & 7) : (a & 7);
      wt  = (i == 0 || (idx & mask) == 0) ? fw : pw;
      for (int j = 0; j <= wt; j++) begin
        e = '{oe_n: 1'b0, chk_addr: 1'b1, addr: a, bv: (i > 0 && j == 0), data: prev, dn: 1'b0};
        exp_q.push_back(e);
      end
      prev = w ? fdat(a) : (fdat(a) & 8'hFF);
      last = a;
      a = (a + (w ? 2 : 1)) & 24'hFFFFFF;
    end
    e = '{oe_n: 1'b0, chk_addr: 1'b1, addr: last, bv: 1'b1, data: prev, dn: 1'b0};
    exp_q.push_back(e);
    e = '{oe_n: 1'b1, chk_addr: 1'b0, addr: 0, bv: 1'b0, data: 0, dn: 1'b1};
    exp_q.push_back(e);
    beats_want = n;
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else e = '{oe_n: 1'b1, chk_addr: 1'b0, addr: 0, bv: 1'b0, data: 0, dn: 1'b0};
      chk(flash_oe_n == e.oe_n, "R9 oe_n", int'(flash_oe_n), int'(e.oe_n));
      chk(flash_cs_n == e.oe_n, "R9 cs_n", int'(flash_cs_n), int'(e.oe_n));
      chk(req_ready == e.oe_n, "R2 ready", int'(req_ready), int'(e.oe_n));
      chk(beat_valid == e.bv, "R4/R5/R6/R11 beat timing", int'(beat_valid), int'(e.bv));
      if (e.chk_addr)
        chk(int'(flash_addr) == e.addr, "R7 address", int'(flash_addr), e.addr);
      if (e.bv && beat_valid)
        chk(int'(beat_data) == e.data, "R8 data", int'(beat_data), e.data);
      chk(done == e.dn, "R10 done", int'(done), int'(e.dn));
      if (beat_valid) beats_seen++;
      if (done) begin
        chk(beats_seen == beats_want, "R3 beat count", beats_seen, beats_want);
        beats_seen = 0;
      end
      if (req_valid && req_ready)
        build(int'(req_addr), int'(req_len), int'(req_page), req_wide,
              int'(cfg_first_wait), int'(cfg_page_wait));
    end
  end

  // called at posedge+1; leaves at posedge+1 right after acceptance
  task automatic req(input int a, input int lc, input int pc, input bit w);
    req_addr  = AW'(a);
    req_len   = 2'(lc);
    req_page  = 2'(pc);
    req_wide  = w;
    req_valid = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk(flash_cs_n && flash_oe_n, "R1 bus idle in reset", int'(flash_oe_n), 1);
    chk(!beat_valid && !done, "R1 pulses low in reset", int'(beat_valid), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    @(posedge clk);
    #1;
    // 8-bit, 8 beats, 4-word page, start mid-page -> page crossing (R6)
    req(24'h000102, 3, 1, 1'b0);
    // held request while busy, 16-bit, odd address, 2-word page (R2, R7)
    req(24'h000207, 2, 0, 1'b1);
    // change waits mid-burst: must not affect the running burst (R11)
    cfg_first_wait = 4'd0;
    cfg_page_wait  = 4'd0;
    idle(40);
    // single beat, zero waits (R3, R4)
    req(24'h00ABCD, 0, 2, 1'b1);
    idle(6);
    // page code 3 acts as 8 words, aligned, no crossing (R6)
    cfg_first_wait = 4'd15;
    cfg_page_wait  = 4'd1;
    req(24'h001010, 3, 3, 1'b1);
    idle(60);
    // 2 beats straddling a 2-word page end in 8-bit mode (R6)
    cfg_first_wait = 4'd2;
    cfg_page_wait  = 4'd5;
    req(24'h0000F1, 1, 0, 1'b0);
    // back-to-back with longer page wait, 8 beats in 8-word pages
    req(24'h0000F8, 3, 2, 1'b0);
    while (exp_q.size() > 0) @(posedge clk);
    idle(4);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule